// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter decides, for each received frame, whether the frame is kept or discarded. The MAC presents the 48-bit destination address of the frame with a one-cycle strobe, together with two frame attributes: one flag marks a MAC control frame and one flag marks a damaged (errored) frame. One clock later the filter returns a registered decision with its own valid flag.

The decision depends on the class of the address and on a set of mode inputs. The address classes are broadcast, multicast and unicast. The mode inputs are a station address, a 64-bin hash table and seven mode bits. The hash bin of an address is chosen by a CRC-32 that the block computes on its own, in a single cycle, from the address bits in wire order. The hash table can apply to multicast addresses, to unicast addresses, or to both. Broadcast, control and damaged frames each have their own pass or drop bit. A promiscuous bit overrides the address checks and the control check.

There is no back-pressure on either side. A new address may be strobed on every clock, and every strobe produces exactly one decision one cycle later, whatever the strobe pattern. The consumer of the decision cannot stall it. The configuration inputs are sampled in the same cycle as the strobe.

Top module: `rx_addr_filter`

## Requirements
- R1: `dec_valid` is high in the cycle after each cycle in which `da_valid` is high, and low otherwise, including for back-to-back strobes.
- R2: After reset, and in every cycle where `dec_valid` is low, `dec_accept` is low.
- R3: A frame with `da_err`=1 is rejected when `cfg_pass_bad`=0. When `cfg_pass_bad`=1, it is filtered like an undamaged frame.
- R4: With `cfg_promisc`=1, every frame with `da_err`=0 is accepted, whatever its address and its control flag.
- R5: A broadcast address (all 48 bits one) is accepted if and only if `cfg_pass_bcast`=1 (promiscuous off, frame not control or damaged).
- R6: A multicast address has bit 40 set (bit 0 of the first octet, which is `da[47:40]`) and is not all ones. It is accepted when `cfg_mc_all`=1, or when `cfg_mc_hash`=1 and its hash bin is set. Otherwise it is rejected.
- R7: A unicast address (bit 40 clear) that equals `cfg_station` is accepted.
- R8: A unicast address that does not equal `cfg_station` is accepted only when `cfg_uc_hash`=1 and its hash bin is set.
- R9: The hash bin is `cfg_hash[k]`, where k is bits 31:26 of a CRC register. The register starts at all ones and is fed with the address octets in the order `da[47:40]` first through `da[7:0]` last, each octet least-significant bit first. Each step is: shift the register right by one, then XOR 0xEDB88320 when the old bit 0 differed from the input bit. There is no final inversion.
- R10: A frame with `da_ctrl`=1 is rejected unless `cfg_pass_ctrl`=1 or `cfg_promisc`=1. When it passes, its address is filtered as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da_addr | input | 48 | Destination address; `[47:40]` is the first octet on the wire |
| da_ctrl | input | 1 | Frame is a MAC control frame |
| da_err | input | 1 | Frame is damaged |
| cfg_station | input | 48 | Station unicast address |
| cfg_hash | input | 64 | Hash table, one bit per bin |
| cfg_promisc | input | 1 | Accept all undamaged frames |
| cfg_pass_bcast | input | 1 | Pass broadcast frames |
| cfg_mc_all | input | 1 | Pass all multicast frames |
| cfg_mc_hash | input | 1 | Filter multicast frames through the hash table |
| cfg_uc_hash | input | 1 | Also accept unicast frames that hit the hash table |
| cfg_pass_ctrl | input | 1 | Pass control frames |
| cfg_pass_bad | input | 1 | Pass damaged frames to the address filter |
| dec_valid | output | 1 | Decision valid, one cycle after `da_valid` |
| dec_accept | output | 1 | Frame accepted; low whenever `dec_valid` is low |

## Verification
The assertions assume that `da_valid`, `da_err`, `da_ctrl`, `da_addr` and the mode bits are known and settled at every rising edge after reset. They also assume that the mode bits seen at the strobe edge are the ones that govern the decision. The stimulus meets these assumptions: every input changes only on the falling clock edge, and every mode bit is held constant from the strobe until the decision is sampled. The hash-bin cases set exactly one bin, or every bin except one, for each address used. This way a wrong bin index shows up as a wrong decision.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W  = 48;
  localparam int OCTET_W = 8;
  localparam int N_OCTET = ADDR_W / OCTET_W;
  localparam int CRC_W   = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic promisc;
    logic pass_bcast;
    logic mc_all;
    logic mc_hash;
    logic uc_hash;
    logic pass_ctrl;
    logic pass_bad;
  } rxf_mode_t;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } rxf_class_e;

  // Ethernet-order CRC: first octet is the top byte, each octet LSB first.
  function automatic logic [CRC_W-1:0] rxf_crc(input logic [ADDR_W-1:0] a);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '1;
    for (int o = 0; o < N_OCTET; o++) begin
      for (int b = 0; b < OCTET_W; b++) begin
        fb = c[0] ^ a[ADDR_W - OCTET_W*(o+1) + b];
        c  = c >> 1;
        if (fb) c = c ^ CRC_POLY;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_hash_index.sv
module rxf_hash_index
  import rxf_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [HASH_W-1:0] index
);
  logic [CRC_W-1:0] crc;

  always_comb begin
    crc   = rxf_crc(addr);
    index = crc[CRC_W-1 -: HASH_W];
  end
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] station,
  output rxf_class_e        cls,
  output logic              station_hit
);
  localparam int GROUP_BIT = ADDR_W - OCTET_W;

  always_comb begin
    if (&addr)               cls = CLS_BCAST;
    else if (addr[GROUP_BIT]) cls = CLS_MCAST;
    else                     cls = CLS_UCAST;
    station_hit = (addr == station);
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  rxf_class_e cls,
  input  logic       station_hit,
  input  logic       hash_hit,
  input  logic       is_ctrl,
  input  logic       is_err,
  input  rxf_mode_t  mode,
  output logic       accept
);
  logic addr_ok;
  logic ctrl_ok;
  logic err_ok;

  always_comb begin
    unique case (cls)
      CLS_BCAST: addr_ok = mode.pass_bcast;
      CLS_MCAST: addr_ok = mode.mc_all | (mode.mc_hash & hash_hit);
      default:   addr_ok = station_hit | (mode.uc_hash & hash_hit);
    endcase
    ctrl_ok = ~is_ctrl | mode.pass_ctrl;
    err_ok  = ~is_err | mode.pass_bad;
    accept  = err_ok & (mode.promisc | (addr_ok & ctrl_ok));
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int HASH_W = 6,
  localparam int BINS  = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da_addr,
  input  logic              da_ctrl,
  input  logic              da_err,
  input  logic [ADDR_W-1:0] cfg_station,
  input  logic [BINS-1:0]   cfg_hash,
  input  logic              cfg_promisc,
  input  logic              cfg_pass_bcast,
  input  logic              cfg_mc_all,
  input  logic              cfg_mc_hash,
  input  logic              cfg_uc_hash,
  input  logic              cfg_pass_ctrl,
  input  logic              cfg_pass_bad,
  output logic              dec_valid,
  output logic              dec_accept
);
  rxf_mode_t         mode;
  rxf_class_e        cls;
  logic [HASH_W-1:0] bin;
  logic              station_hit;
  logic              hash_hit;
  logic              accept_c;

  assign mode = '{promisc:    cfg_promisc,
                  pass_bcast: cfg_pass_bcast,
                  mc_all:     cfg_mc_all,
                  mc_hash:    cfg_mc_hash,
                  uc_hash:    cfg_uc_hash,
                  pass_ctrl:  cfg_pass_ctrl,
                  pass_bad:   cfg_pass_bad};

  rxf_hash_index #(.HASH_W(HASH_W)) u_hash (
    .addr  (da_addr),
    .index (bin)
  );

  rxf_classify u_cls (
    .addr        (da_addr),
    .station     (cfg_station),
    .cls         (cls),
    .station_hit (station_hit)
  );

  assign hash_hit = cfg_hash[bin];

  rxf_decide u_dec (
    .cls         (cls),
    .station_hit (station_hit),
    .hash_hit    (hash_hit),
    .is_ctrl     (da_ctrl),
    .is_err      (da_err),
    .mode        (mode),
    .accept      (accept_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= da_valid;
      dec_accept <= da_valid & accept_c;
    end
  end

  // R1: one decision per strobe, one cycle later
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> dec_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !dec_valid);
  // R2: accept only qualified by valid
  a_r2_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
  // R3: damaged frames dropped unless passed
  a_r3_bad_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_err && !cfg_pass_bad) |=> !dec_accept);
  // R4: promiscuous keeps every clean frame
  a_r4_promisc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cfg_promisc && !da_err) |=> dec_accept);
  // R5: broadcast drop when not passed
  a_r5_bcast_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da_addr) && !cfg_promisc && !cfg_pass_bcast) |=> !dec_accept);
  // R10: control frames dropped unless passed
  a_r10_ctrl_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_ctrl && !cfg_pass_ctrl && !cfg_promisc) |=> !dec_accept);
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        da_ctrl = 1'b0;
  logic        da_err = 1'b0;
  logic [47:0] cfg_station = 48'h02_11_22_33_44_55;
  logic [63:0] cfg_hash = '0;
  logic        cfg_promisc = 1'b0, cfg_pass_bcast = 1'b0, cfg_mc_all = 1'b0;
  logic        cfg_mc_hash = 1'b0, cfg_uc_hash = 1'b0, cfg_pass_ctrl = 1'b0;
  logic        cfg_pass_bad = 1'b0;
  logic        dec_valid, dec_accept;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  rx_addr_filter u0 (
    .clk, .rst_n, .da_valid, .da_addr, .da_ctrl, .da_err,
    .cfg_station, .cfg_hash, .cfg_promisc, .cfg_pass_bcast, .cfg_mc_all,
    .cfg_mc_hash, .cfg_uc_hash, .cfg_pass_ctrl, .cfg_pass_bad,
    .dec_valid, .dec_accept
  );

  // Bin index per R9
  function automatic int bin_of(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int o = 0; o < 6; o++) begin
      logic [7:0] oct = a[47 - 8*o -: 8];
      for (int b = 0; b < 8; b++) begin
        logic x = r[0] ^ oct[b];
        r = {1'b0, r[31:1]};
        if (x) r = r ^ 32'hEDB88320;
      end
    end
    return int'(r[31:26]);
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic clear_cfg();
    @(negedge clk);
    cfg_hash = '0;
    {cfg_promisc, cfg_pass_bcast, cfg_mc_all, cfg_mc_hash,
     cfg_uc_hash, cfg_pass_ctrl, cfg_pass_bad} = '0;
  endtask

  // strobe one address, check the decision one cycle later
  task automatic send(input logic [47:0] a, input logic c, input logic e,
                      input logic exp, input string req);
    @(negedge clk);
    da_valid = 1'b1; da_addr = a; da_ctrl = c; da_err = e;
    @(negedge clk);
    da_valid = 1'b0; da_ctrl = 1'b0; da_err = 1'b0;
    check(dec_valid, 1'b1, {req, " valid"});
    check(dec_accept, exp, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(dec_valid, 1'b0, "R2 reset valid");
    check(dec_accept, 1'b0, "R2 reset accept");
  endtask

  task automatic t_unicast();
    clear_cfg();
    send(cfg_station, 1'b0, 1'b0, 1'b1, "R7 station match");
    send(48'h02_11_22_33_44_54, 1'b0, 1'b0, 1'b0, "R8 mismatch no hash");
    @(negedge clk);
    check(dec_valid, 1'b0, "R1 idle after single strobe");
    check(dec_accept, 1'b0, "R2 idle accept low");
  endtask

  task automatic t_broadcast();
    clear_cfg();
    send('1, 1'b0, 1'b0, 1'b0, "R5 bcast dropped");
    cfg_pass_bcast = 1'b1;
    send('1, 1'b0, 1'b0, 1'b1, "R5 bcast passed");
    cfg_mc_all = 1'b1; cfg_pass_bcast = 1'b0;
    send('1, 1'b0, 1'b0, 1'b0, "R5 bcast not multicast");
  endtask

  task automatic t_mcast();
    logic [47:0] m = 48'h01_00_5E_00_00_FB;
    int k = bin_of(m);
    clear_cfg();
    send(m, 1'b0, 1'b0, 1'b0, "R6 mcast no mode");
    cfg_mc_all = 1'b1;
    send(m, 1'b0, 1'b0, 1'b1, "R6 mcast all");
    cfg_mc_all = 1'b0; cfg_mc_hash = 1'b1; cfg_hash = '0; cfg_hash[k] = 1'b1;
    send(m, 1'b0, 1'b0, 1'b1, "R6 mcast hash hit");
    cfg_hash = '1; cfg_hash[k] = 1'b0;
    send(m, 1'b0, 1'b0, 1'b0, "R6 mcast hash miss");
    cfg_mc_hash = 1'b0; cfg_uc_hash = 1'b1; cfg_hash = '1;
    send(m, 1'b0, 1'b0, 1'b0, "R6 uc hash ignores mcast");
  endtask

  task automatic t_hash_bins();
    logic [47:0] addrs [4] = '{48'h00_0A_95_9D_68_16, 48'h33_33_00_00_00_01,
                               48'h12_34_56_78_9A_BC, 48'h00_00_00_00_00_01};
    clear_cfg();
    cfg_uc_hash = 1'b1; cfg_mc_hash = 1'b1;
    for (int i = 0; i < 4; i++) begin
      int k = bin_of(addrs[i]);
      cfg_hash = '0; cfg_hash[k] = 1'b1;
      send(addrs[i], 1'b0, 1'b0, 1'b1, "R9 single bin hit");
      cfg_hash = '1; cfg_hash[k] = 1'b0;
      send(addrs[i], 1'b0, 1'b0, 1'b0, "R9 single bin miss");
    end
  endtask

  task automatic t_uc_hash();
    logic [47:0] u = 48'h00_1B_21_3C_4D_5E;
    int k = bin_of(u);
    clear_cfg();
    cfg_hash[k] = 1'b1;
    send(u, 1'b0, 1'b0, 1'b0, "R8 uc hash off");
    cfg_uc_hash = 1'b1;
    send(u, 1'b0, 1'b0, 1'b1, "R8 uc hash hit");
  endtask

  task automatic t_ctrl();
    clear_cfg();
    send(cfg_station, 1'b1, 1'b0, 1'b0, "R10 ctrl dropped");
    cfg_pass_ctrl = 1'b1;
    send(cfg_station, 1'b1, 1'b0, 1'b1, "R10 ctrl passed");
    send(48'h00_99_99_99_99_99, 1'b1, 1'b0, 1'b0, "R10 ctrl still address filtered");
  endtask

  task automatic t_damaged();
    clear_cfg();
    send(cfg_station, 1'b0, 1'b1, 1'b0, "R3 bad dropped");
    cfg_pass_bad = 1'b1;
    send(cfg_station, 1'b0, 1'b1, 1'b1, "R3 bad passed");
    send(48'h00_99_99_99_99_99, 1'b0, 1'b1, 1'b0, "R3 bad address filtered");
  endtask

  task automatic t_promisc();
    clear_cfg();
    cfg_promisc = 1'b1;
    send(48'h00_77_66_55_44_33, 1'b0, 1'b0, 1'b1, "R4 promisc unicast");
    send('1, 1'b0, 1'b0, 1'b1, "R4 promisc bcast");
    send(48'h01_80_C2_00_00_01, 1'b1, 1'b0, 1'b1, "R4 promisc ctrl");
    send(48'h00_77_66_55_44_33, 1'b0, 1'b1, 1'b0, "R4 promisc bad dropped");
  endtask

  task automatic t_stream();
    clear_cfg();
    @(negedge clk);
    da_valid = 1'b1; da_addr = cfg_station;
    @(negedge clk);
    da_addr = 48'h00_00_00_00_00_02;
    check(dec_valid, 1'b1, "R1 back-to-back first valid");
    check(dec_accept, 1'b1, "R1 back-to-back first accept");
    @(negedge clk);
    da_addr = cfg_station;
    check(dec_valid, 1'b1, "R1 back-to-back second valid");
    check(dec_accept, 1'b0, "R1 back-to-back second reject");
    @(negedge clk);
    da_valid = 1'b0;
    check(dec_accept, 1'b1, "R1 back-to-back third accept");
    @(negedge clk);
    check(dec_valid, 1'b0, "R1 valid drops after burst");
    check(dec_accept, 1'b0, "R2 accept drops after burst");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unicast();
    t_broadcast();
    t_mcast();
    t_hash_bins();
    t_uc_hash();
    t_ctrl();
    t_damaged();
    t_promisc();
    t_stream();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule